// File: doc/BRIEF.md
# Paged Packet Memory Allocator

This block keeps the bookkeeping for a packet buffer that is divided into 2048-byte pages. A requester asks for a page and receives a packet number and a success flag. Freed packet numbers return to the pool. The number handed out is always the lowest-numbered free page. The pool holds at most 64 pages, which is 128 KB, so packet numbers and page numbers are the same thing. The RAM that holds packet bytes, the host bus and the MAC datapath are outside this block.

Free memory and the allocation limit use 512-byte units, so one page counts as four units. A programmable limit caps how much of the buffer may be in use at once. Beside the allocator sit three first-in first-out queues of packet numbers: a transmit queue, a transmit-completion queue and a receive queue. The transmit interrupt is taken from the completion queue and the receive interrupt from the receive queue.

The allocation request and response use valid/ready. A request is taken only when `alloc_req_ready` is high, and `alloc_req_ready` is low while a response is waiting and `alloc_rsp_ready` is low. A waiting response holds its values until it is taken. Each queue's push side refuses data while the queue is full. Its pop side presents the oldest entry whenever the queue is not empty. Release, the limit and the status outputs are plain signals; a release is always taken in the cycle it is presented.

Top module: `pkt_alloc_mmu`

## Requirements
- R1: After reset all pages are free, `free_units` reads 256, every queue is empty, both interrupts and `dbl_free_err` are low, and `alloc_rsp_valid` is low.
- R2: In the cycle after a request is taken, `alloc_rsp_valid` is high. If the request succeeds, `alloc_rsp_ok` is 1 and `alloc_rsp_pkt` is the lowest-numbered page that was free when the request was taken.
- R3: A request taken while no page is free returns `alloc_rsp_ok` = 0 and `alloc_rsp_pkt` = 0, and it changes no allocation state.
- R4: A request is refused (`alloc_rsp_ok` = 0, `alloc_rsp_pkt` = 0) when (pages in use + 1) x 4 is greater than `limit_units`. The limit is counted in 512-byte units.
- R5: `free_units` equals 4 x (64 - pages in use). It takes the new value in the cycle after an allocation or release takes effect.
- R6: When `rel_valid` names a page that is allocated, that page becomes free from the next cycle and can be handed out again.
- R7: A release that names a page that is already free changes no page state. It sets `dbl_free_err`, which stays high until reset.
- R8: While `alloc_rsp_valid` is high and `alloc_rsp_ready` is low, `alloc_req_ready` is low and the response fields hold their values.
- R9: Each of the three queues returns packet numbers in the order they were pushed, independently of the other two. It holds 64 entries. While it is full, `*_in_ready` is low and offered data is not stored.
- R10: `tx_irq` is high exactly while the completion queue is non-empty, and `rx_irq` is high exactly while the receive queue is non-empty. The transmit queue drives neither interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req_valid | input | 1 | Allocation request |
| alloc_req_ready | output | 1 | Request can be taken |
| alloc_rsp_valid | output | 1 | Response present |
| alloc_rsp_ready | input | 1 | Response taken by requester |
| alloc_rsp_ok | output | 1 | 1 = page granted, 0 = refused |
| alloc_rsp_pkt | output | 6 | Granted packet number, 0 when refused |
| rel_valid | input | 1 | Release the page named by rel_pkt |
| rel_pkt | input | 6 | Packet number to release |
| limit_units | input | 9 | Allocation limit in 512-byte units |
| free_units | output | 9 | Free memory in 512-byte units |
| dbl_free_err | output | 1 | Sticky: release of a free page seen |
| txq_in_valid | input | 1 | Transmit queue push |
| txq_in_ready | output | 1 | Transmit queue not full |
| txq_in_pkt | input | 6 | Packet number to push |
| txq_out_valid | output | 1 | Transmit queue not empty |
| txq_out_ready | input | 1 | Pop transmit queue head |
| txq_out_pkt | output | 6 | Transmit queue head |
| doneq_in_valid | input | 1 | Completion queue push |
| doneq_in_ready | output | 1 | Completion queue not full |
| doneq_in_pkt | input | 6 | Packet number to push |
| doneq_out_valid | output | 1 | Completion queue not empty |
| doneq_out_ready | input | 1 | Pop completion queue head |
| doneq_out_pkt | output | 6 | Completion queue head |
| rxq_in_valid | input | 1 | Receive queue push |
| rxq_in_ready | output | 1 | Receive queue not full |
| rxq_in_pkt | input | 6 | Packet number to push |
| rxq_out_valid | output | 1 | Receive queue not empty |
| rxq_out_ready | input | 1 | Pop receive queue head |
| rxq_out_pkt | output | 6 | Receive queue head |
| tx_irq | output | 1 | Completion queue non-empty |
| rx_irq | output | 1 | Receive queue non-empty |

## Verification
Back-to-back requests from an empty pool check that numbers come out in ascending order. Releasing one page in the middle and then allocating again checks that the encoder goes back to the lowest hole instead of continuing from the last grant. A tight limit and a fully used pool each produce a refusal, one for each cause, and the bench separates the two causes by recording which one should apply. A long random mix of requests, stalled responses, releases of both allocated and free pages, and pushes and pops on all three queues checks that the page state, the free count, the sticky error and the queue contents stay consistent with each other.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  localparam int unsigned PAGE_BYTES     = 2048;
  localparam int unsigned UNIT_BYTES     = 512;
  localparam int unsigned UNITS_PER_PAGE = PAGE_BYTES / UNIT_BYTES;

  localparam int unsigned NUM_Q  = 3;
  localparam int unsigned Q_TX   = 0;
  localparam int unsigned Q_DONE = 1;
  localparam int unsigned Q_RX   = 2;

  typedef enum logic [1:0] {
    GRANT_OK         = 2'd0,
    GRANT_NO_PAGE    = 2'd1,
    GRANT_OVER_LIMIT = 2'd2
  } grant_e;
endpackage

// File: rtl/pkt_low_free_enc.sv
module pkt_low_free_enc #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan from the top so the last hit written is the lowest free page.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pkt_page_pool.sv
module pkt_page_pool
  import pkt_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 64,
  parameter int unsigned PKT_W     = 6,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned UNIT_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [UNIT_W-1:0] limit_units,
  input  logic              rel_valid,
  input  logic [PKT_W-1:0]  rel_pkt,
  output grant_e            grant,
  output logic [PKT_W-1:0]  grant_pkt,
  output logic [CNT_W-1:0]  used_pages,
  output logic              dbl_free_err
);
  logic [NUM_PAGES-1:0] busy_q, busy_n;
  logic [CNT_W-1:0]     used_q;
  logic                 err_q;
  logic                 any_free;
  logic [UNIT_W:0]      need_units;
  logic                 alloc_ok, rel_in_range, rel_hit;

  pkt_low_free_enc #(.N(NUM_PAGES), .IW(PKT_W)) u_enc (
    .busy  (busy_q),
    .found (any_free),
    .idx   (grant_pkt)
  );

  assign need_units = ((UNIT_W+1)'(used_q) + (UNIT_W+1)'(1)) * (UNIT_W+1)'(UNITS_PER_PAGE);

  always_comb begin
    if (!any_free)                        grant = GRANT_NO_PAGE;
    else if (need_units > {1'b0, limit_units}) grant = GRANT_OVER_LIMIT;
    else                                  grant = GRANT_OK;
  end

  assign alloc_ok     = take && (grant == GRANT_OK);
  assign rel_in_range = ({1'b0, rel_pkt} < (PKT_W+1)'(NUM_PAGES));
  assign rel_hit      = rel_valid && rel_in_range && busy_q[rel_pkt];

  always_comb begin
    busy_n = busy_q;
    if (alloc_ok) busy_n[grant_pkt] = 1'b1;
    if (rel_hit)  busy_n[rel_pkt]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      used_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      unique case ({alloc_ok, rel_hit})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
      if (rel_valid && !rel_hit) err_q <= 1'b1;
    end
  end

  assign used_pages   = used_q;
  assign dbl_free_err = err_q;
endmodule

// File: rtl/pkt_num_fifo.sv
module pkt_num_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt_q != CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pkt_alloc_mmu.sv
module pkt_alloc_mmu
  import pkt_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 64,
  localparam int unsigned PKT_W    = $clog2(NUM_PAGES),
  localparam int unsigned CNT_W    = $clog2(NUM_PAGES + 1),
  localparam int unsigned UNIT_W   = $clog2(NUM_PAGES * UNITS_PER_PAGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req_valid,
  output logic              alloc_req_ready,
  output logic              alloc_rsp_valid,
  input  logic              alloc_rsp_ready,
  output logic              alloc_rsp_ok,
  output logic [PKT_W-1:0]  alloc_rsp_pkt,
  input  logic              rel_valid,
  input  logic [PKT_W-1:0]  rel_pkt,
  input  logic [UNIT_W-1:0] limit_units,
  output logic [UNIT_W-1:0] free_units,
  output logic              dbl_free_err,
  input  logic              txq_in_valid,
  output logic              txq_in_ready,
  input  logic [PKT_W-1:0]  txq_in_pkt,
  output logic              txq_out_valid,
  input  logic              txq_out_ready,
  output logic [PKT_W-1:0]  txq_out_pkt,
  input  logic              doneq_in_valid,
  output logic              doneq_in_ready,
  input  logic [PKT_W-1:0]  doneq_in_pkt,
  output logic              doneq_out_valid,
  input  logic              doneq_out_ready,
  output logic [PKT_W-1:0]  doneq_out_pkt,
  input  logic              rxq_in_valid,
  output logic              rxq_in_ready,
  input  logic [PKT_W-1:0]  rxq_in_pkt,
  output logic              rxq_out_valid,
  input  logic              rxq_out_ready,
  output logic [PKT_W-1:0]  rxq_out_pkt,
  output logic              tx_irq,
  output logic              rx_irq
);
  grant_e           grant;
  logic [PKT_W-1:0] grant_pkt;
  logic [CNT_W-1:0] used_pages;
  logic             req_fire;
  logic             rsp_v_q, rsp_ok_q;
  logic [PKT_W-1:0] rsp_pkt_q;

  assign alloc_req_ready = !rsp_v_q || alloc_rsp_ready;
  assign req_fire        = alloc_req_valid && alloc_req_ready;

  pkt_page_pool #(
    .NUM_PAGES (NUM_PAGES),
    .PKT_W     (PKT_W),
    .CNT_W     (CNT_W),
    .UNIT_W    (UNIT_W)
  ) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (req_fire),
    .limit_units  (limit_units),
    .rel_valid    (rel_valid),
    .rel_pkt      (rel_pkt),
    .grant        (grant),
    .grant_pkt    (grant_pkt),
    .used_pages   (used_pages),
    .dbl_free_err (dbl_free_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q   <= 1'b0;
      rsp_ok_q  <= 1'b0;
      rsp_pkt_q <= '0;
    end else if (req_fire) begin
      rsp_v_q   <= 1'b1;
      rsp_ok_q  <= (grant == GRANT_OK);
      rsp_pkt_q <= (grant == GRANT_OK) ? grant_pkt : '0;
    end else if (alloc_rsp_ready) begin
      rsp_v_q   <= 1'b0;
    end
  end

  assign alloc_rsp_valid = rsp_v_q;
  assign alloc_rsp_ok    = rsp_ok_q;
  assign alloc_rsp_pkt   = rsp_pkt_q;

  assign free_units = UNIT_W'(NUM_PAGES * UNITS_PER_PAGE)
                    - UNIT_W'(used_pages) * UNIT_W'(UNITS_PER_PAGE);

  // Queue ports gathered into arrays so one generate loop builds all three.
  logic             q_in_valid  [NUM_Q];
  logic             q_in_ready  [NUM_Q];
  logic [PKT_W-1:0] q_in_pkt    [NUM_Q];
  logic             q_out_valid [NUM_Q];
  logic             q_out_ready [NUM_Q];
  logic [PKT_W-1:0] q_out_pkt   [NUM_Q];

  assign q_in_valid[Q_TX]   = txq_in_valid;
  assign q_in_pkt[Q_TX]     = txq_in_pkt;
  assign q_out_ready[Q_TX]  = txq_out_ready;
  assign q_in_valid[Q_DONE] = doneq_in_valid;
  assign q_in_pkt[Q_DONE]   = doneq_in_pkt;
  assign q_out_ready[Q_DONE]= doneq_out_ready;
  assign q_in_valid[Q_RX]   = rxq_in_valid;
  assign q_in_pkt[Q_RX]     = rxq_in_pkt;
  assign q_out_ready[Q_RX]  = rxq_out_ready;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    pkt_num_fifo #(.DEPTH(NUM_PAGES), .W(PKT_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (q_in_valid[q]),
      .in_ready  (q_in_ready[q]),
      .in_data   (q_in_pkt[q]),
      .out_valid (q_out_valid[q]),
      .out_ready (q_out_ready[q]),
      .out_data  (q_out_pkt[q])
    );
  end

  assign txq_in_ready    = q_in_ready[Q_TX];
  assign txq_out_valid   = q_out_valid[Q_TX];
  assign txq_out_pkt     = q_out_pkt[Q_TX];
  assign doneq_in_ready  = q_in_ready[Q_DONE];
  assign doneq_out_valid = q_out_valid[Q_DONE];
  assign doneq_out_pkt   = q_out_pkt[Q_DONE];
  assign rxq_in_ready    = q_in_ready[Q_RX];
  assign rxq_out_valid   = q_out_valid[Q_RX];
  assign rxq_out_pkt     = q_out_pkt[Q_RX];

  assign tx_irq = q_out_valid[Q_DONE];
  assign rx_irq = q_out_valid[Q_RX];
endmodule

// File: rtl/pkt_alloc_mmu_chk.sv
module pkt_alloc_mmu_chk
  import pkt_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 64,
  parameter int unsigned PKT_W     = 6,
  parameter int unsigned UNIT_W    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_req_valid,
  input logic              alloc_req_ready,
  input logic              alloc_rsp_valid,
  input logic              alloc_rsp_ready,
  input logic              alloc_rsp_ok,
  input logic [PKT_W-1:0]  alloc_rsp_pkt,
  input logic [UNIT_W-1:0] limit_units,
  input logic [UNIT_W-1:0] free_units,
  input logic              dbl_free_err,
  input logic              rxq_in_valid,
  input logic              rxq_in_ready,
  input logic              doneq_out_valid,
  input logic              doneq_out_ready,
  input logic              tx_irq,
  input logic              rx_irq
);
  logic            fire;
  logic [UNIT_W:0] used_units;

  assign fire       = alloc_req_valid && alloc_req_ready;
  assign used_units = (UNIT_W+1)'(NUM_PAGES * UNITS_PER_PAGE) - {1'b0, free_units};

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alloc_rsp_valid); // R2

  AST_NO_PAGE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && free_units == '0) |=> (!alloc_rsp_ok && alloc_rsp_pkt == '0)); // R3

  AST_LIMIT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (used_units + (UNIT_W+1)'(UNITS_PER_PAGE) > {1'b0, limit_units}))
      |=> !alloc_rsp_ok); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_free_err |=> dbl_free_err); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_rsp_valid && !alloc_rsp_ready)
      |=> (alloc_rsp_valid && $stable(alloc_rsp_ok) && $stable(alloc_rsp_pkt))); // R8

  AST_RX_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rxq_in_valid && rxq_in_ready)); // R10

  AST_TX_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_irq) |-> $past(doneq_out_valid && doneq_out_ready)); // R10
endmodule

bind pkt_alloc_mmu pkt_alloc_mmu_chk #(
  .NUM_PAGES (NUM_PAGES),
  .PKT_W     (PKT_W),
  .UNIT_W    (UNIT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .alloc_req_valid (alloc_req_valid),
  .alloc_req_ready (alloc_req_ready),
  .alloc_rsp_valid (alloc_rsp_valid),
  .alloc_rsp_ready (alloc_rsp_ready),
  .alloc_rsp_ok    (alloc_rsp_ok),
  .alloc_rsp_pkt   (alloc_rsp_pkt),
  .limit_units     (limit_units),
  .free_units      (free_units),
  .dbl_free_err    (dbl_free_err),
  .rxq_in_valid    (rxq_in_valid),
  .rxq_in_ready    (rxq_in_ready),
  .doneq_out_valid (doneq_out_valid),
  .doneq_out_ready (doneq_out_ready),
  .tx_irq          (tx_irq),
  .rx_irq          (rx_irq)
);

// File: tb/pkt_alloc_mmu_bench.sv
module pkt_alloc_mmu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 64;
  localparam int UPP  = 4;
  localparam int SEED = 1234;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_valid = 1'b0, a_ready, rsp_valid, rsp_rdy = 1'b1, rsp_ok;
  logic [5:0] rsp_pkt;
  logic       r_valid = 1'b0;
  logic [5:0] r_pkt = '0;
  logic [8:0] lim = 9'd256;
  logic [8:0] free_units;
  logic       err, tx_irq, rx_irq;
  logic [2:0] pv = '0, pr = '0, ir, ov;
  logic [5:0] pd [3];
  logic [5:0] od [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_alloc_mmu u_pkt_alloc_mmu (
    .clk(clk), .rst_n(rst_n),
    .alloc_req_valid(a_valid), .alloc_req_ready(a_ready),
    .alloc_rsp_valid(rsp_valid), .alloc_rsp_ready(rsp_rdy),
    .alloc_rsp_ok(rsp_ok), .alloc_rsp_pkt(rsp_pkt),
    .rel_valid(r_valid), .rel_pkt(r_pkt),
    .limit_units(lim), .free_units(free_units), .dbl_free_err(err),
    .txq_in_valid(pv[0]), .txq_in_ready(ir[0]), .txq_in_pkt(pd[0]),
    .txq_out_valid(ov[0]), .txq_out_ready(pr[0]), .txq_out_pkt(od[0]),
    .doneq_in_valid(pv[1]), .doneq_in_ready(ir[1]), .doneq_in_pkt(pd[1]),
    .doneq_out_valid(ov[1]), .doneq_out_ready(pr[1]), .doneq_out_pkt(od[1]),
    .rxq_in_valid(pv[2]), .rxq_in_ready(ir[2]), .rxq_in_pkt(pd[2]),
    .rxq_out_valid(ov[2]), .rxq_out_ready(pr[2]), .rxq_out_pkt(od[2]),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int n_vec = 0, n_fail = 0;

  // Reference state, built only from the requirements.
  bit    mbusy [NP];
  int    mused = 0;
  bit    merr = 0;
  bit    m_rsp_v = 0, m_ok = 0;
  int    m_pkt = 0;
  string m_why = "R2";
  int    mq [3][NP];
  int    mhead [3];
  int    mcnt [3];

  task automatic chk(bit good, string req, int act, int exp);
    n_vec++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (!mbusy[i]) return i;
    return -1;
  endfunction

  task automatic cyc();
    bit acc, ok, hit;
    bit qpush [3];
    bit qpop [3];
    int pick;
    string why;
    acc = a_valid && (!m_rsp_v || rsp_rdy);
    for (int q = 0; q < 3; q++) begin
      qpush[q] = pv[q] && (mcnt[q] < NP);
      qpop[q]  = pr[q] && (mcnt[q] > 0);
    end
    pick = lowest_free();
    ok = 0; why = "R2";
    if (acc) begin
      if (pick < 0)                   begin ok = 0; why = "R3"; end
      else if ((mused+1)*UPP > lim)   begin ok = 0; why = "R4"; end
      else                            begin ok = 1; why = "R2"; end
    end
    hit = r_valid && mbusy[r_pkt];
    @(posedge clk); #1;
    if (ok) begin mbusy[pick] = 1; mused++; end
    if (hit) begin mbusy[r_pkt] = 0; mused--; end
    else if (r_valid) merr = 1;
    if (acc) begin m_rsp_v = 1; m_ok = ok; m_pkt = ok ? pick : 0; m_why = why; end
    else if (rsp_rdy) m_rsp_v = 0;
    for (int q = 0; q < 3; q++) begin
      if (qpop[q]) begin mhead[q] = (mhead[q] + 1) % NP; mcnt[q]--; end
      if (qpush[q]) begin mq[q][(mhead[q] + mcnt[q]) % NP] = int'(pd[q]); mcnt[q]++; end
    end
    chk(rsp_valid == m_rsp_v, "R8", int'(rsp_valid), int'(m_rsp_v));
    if (m_rsp_v) begin
      chk(rsp_ok == m_ok, m_why, int'(rsp_ok), int'(m_ok));
      chk(int'(rsp_pkt) == m_pkt, m_why, int'(rsp_pkt), m_pkt);
    end
    chk(int'(free_units) == (NP - mused) * UPP, "R5", int'(free_units), (NP - mused) * UPP);
    chk(err == merr, "R7", int'(err), int'(merr));
    for (int q = 0; q < 3; q++) begin
      chk(ov[q] == (mcnt[q] > 0), "R9", int'(ov[q]), int'(mcnt[q] > 0));
      if (mcnt[q] > 0) chk(int'(od[q]) == mq[q][mhead[q]], "R9", int'(od[q]), mq[q][mhead[q]]);
      chk(ir[q] == (mcnt[q] < NP), "R9", int'(ir[q]), int'(mcnt[q] < NP));
    end
    chk(tx_irq == (mcnt[1] > 0), "R10", int'(tx_irq), int'(mcnt[1] > 0));
    chk(rx_irq == (mcnt[2] > 0), "R10", int'(rx_irq), int'(mcnt[2] > 0));
  endtask

  task automatic idle();
    a_valid = 0; r_valid = 0; pv = '0; pr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(SEED);
    for (int q = 0; q < 3; q++) begin pd[q] = '0; mhead[q] = 0; mcnt[q] = 0; end
    for (int i = 0; i < NP; i++) mbusy[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk(int'(free_units) == 256, "R1", int'(free_units), 256);
    chk(rsp_valid == 0, "R1", int'(rsp_valid), 0);
    chk(err == 0, "R1", int'(err), 0);
    chk(ov == 3'b000, "R1", int'(ov), 0);
    chk(tx_irq == 0 && rx_irq == 0, "R1", int'({tx_irq, rx_irq}), 0);

    // R2: ascending grants from an empty pool
    a_valid = 1; repeat (3) cyc();
    idle(); cyc();
    // R6: freed middle page is handed out again
    r_valid = 1; r_pkt = 6'd1; cyc(); idle();
    a_valid = 1; cyc(); idle();
    chk(int'(rsp_pkt) == 1, "R6", int'(rsp_pkt), 1);
    cyc();
    // R7: releasing a free page
    r_valid = 1; r_pkt = 6'd20; cyc(); idle();
    chk(err == 1, "R7", int'(err), 1);
    cyc();
    // R4: limit of 8 units with 3 pages in use
    lim = 9'd8; a_valid = 1; cyc(); idle();
    chk(rsp_ok == 0, "R4", int'(rsp_ok), 0);
    lim = 9'd256; cyc();
    // R8: stalled response
    rsp_rdy = 0; a_valid = 1; cyc(); cyc();
    chk(a_ready == 0, "R8", int'(a_ready), 0);
    cyc();
    rsp_rdy = 1; cyc(); idle(); cyc();
    // R3: exhaust the pool
    a_valid = 1; repeat (NP + 2) cyc(); idle(); cyc();
    chk(int'(free_units) == 0 && rsp_ok == 0, "R3", int'(free_units), 0);
    // R9 / R10: fill the receive queue past capacity, then drain
    pv[2] = 1;
    for (int i = 0; i < NP + 3; i++) begin pd[2] = 6'(i * 7); cyc(); end
    chk(ir[2] == 0, "R9", int'(ir[2]), 0);
    pv[2] = 0; pr[2] = 1;
    repeat (NP + 1) cyc();
    idle(); cyc();
    chk(rx_irq == 0, "R10", int'(rx_irq), 1'b0);
    // free everything
    for (int i = 0; i < NP; i++) begin r_valid = 1; r_pkt = 6'(i); cyc(); end
    idle(); cyc();

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      a_valid = ($urandom % 3) == 0;
      rsp_rdy = ($urandom % 4) != 0;
      r_valid = ($urandom % 3) == 0;
      r_pkt   = 6'($urandom % NP);
      if (($urandom % 64) == 0) lim = 9'($urandom % 257);
      for (int q = 0; q < 3; q++) begin
        pv[q] = ($urandom % 2) == 0;
        pr[q] = ($urandom % 3) == 0;
        pd[q] = 6'($urandom % NP);
      end
      cyc();
    end
    idle(); rsp_rdy = 1; cyc();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule